// File: doc/BRIEF.md
# USB Host Controller Fatal-Error and Interrupt Logic

This block gathers the error and event reporting of a USB 2.0 enhanced host controller. It watches the completion status of memory reads that the controller issues. Any read that ends in a master abort or a target abort is treated as a fatal host error. A fatal error sets a sticky host-error status bit and the matching configuration-space abort bits. It can also set a signalled-system-error bit. It then asks the DMA engines to stop, allowing at most one more USB transaction to finish first.

The block also keeps the microframe and frame position. It raises a one-cycle rollover event each time the 1024-entry frame list wraps, which is once every 8192 microframe ticks. It also raises a completion status bit at each interrupt-threshold boundary when a transaction status has been posted to the internal write buffer since the last boundary.

Every status bit is sticky and is cleared by writing one. A single level interrupt line combines the enabled status bits.

The halt sequencer has three states. RUN is normal operation. DRAIN means a fatal error has been seen and the block waits for the in-flight transaction. HALTED means the DMA engines are stopped. The transitions are:
- RUN to DRAIN on a fatal error.
- DRAIN to HALTED when a transaction completes or none is in flight.
- HALTED to RUN on a software run command.

Top module: `hc_fault_irq`

## Requirements
- R1: After reset, `sts`, `cfg_sts`, `dma_halt_req`, `irq` and `flr_evt` are all zero.
- R2: A fatal error is a cycle with `rd_cpl` high and `rd_mabort` or `rd_tabort` high. At the next edge it sets `sts[2]`, the host-error bit. Abort flags without `rd_cpl` have no effect.
- R3: A fatal error with `rd_mabort` sets `cfg_sts[0]`, and one with `rd_tabort` sets `cfg_sts[1]`. When both flags arrive in the same cycle, both bits are set and only one halt sequence starts.
- R4: A fatal error sets `cfg_sts[2]`, the signalled-system-error bit, only when `serr_en` is high in that cycle.
- R5: A fatal error in RUN moves the block to DRAIN. From the next cycle `dma_halt_req` is high. DRAIN moves to HALTED at the first edge where `xact_done` is high or `xact_active` is low. `sts[3]`, the halted bit, is high exactly while in HALTED.
- R6: HALTED is left only when `run_cmd` is high, which returns the block to RUN and drops `dma_halt_req` and `sts[3]`. `run_cmd` in RUN or DRAIN is ignored. Fatal errors in DRAIN or HALTED still set status bits but do not restart the sequence.
- R7: `irq` is high exactly when (`sts[0]` and `en_cmpl`) or (`sts[1]` and `en_roll`) or (`sts[2]` and `en_fatal`). It follows the enables combinationally.
- R8: Bit i of `sts_w1c` clears `sts[i]` (i = 0..2), and bit i of `cfg_w1c` clears `cfg_sts[i]`. A set condition in the same cycle wins over the clear.
- R9: A counter advances on each `uframe_tick`. The tick that wraps it from 8191 to 0 makes `flr_evt` high for exactly the next cycle and sets `sts[1]`.
- R10: A threshold boundary is a tick after which the tick count since reset is a multiple of 2^min(`thr_log2`,6). At a boundary, `sts[0]` is set if `cpl_posted` was high since the previous boundary, including in the boundary cycle itself. Nothing waits on a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cpl | input | 1 | Controller-initiated read completes this cycle |
| rd_mabort | input | 1 | Completion carries master-abort status |
| rd_tabort | input | 1 | Completion carries target-abort status |
| xact_active | input | 1 | A USB transaction is in flight |
| xact_done | input | 1 | A USB transaction completes this cycle |
| uframe_tick | input | 1 | One microframe elapsed |
| cpl_posted | input | 1 | Transaction status posted to the internal write buffer |
| thr_log2 | input | 3 | Log2 of the interrupt threshold in microframes |
| en_cmpl | input | 1 | Completion interrupt enable |
| en_roll | input | 1 | Rollover interrupt enable |
| en_fatal | input | 1 | Host-error interrupt enable |
| serr_en | input | 1 | System-error signalling enable |
| run_cmd | input | 1 | Software run command |
| sts_w1c | input | 3 | Write-one-to-clear strobes for sts[2:0] |
| cfg_w1c | input | 3 | Write-one-to-clear strobes for cfg_sts |
| sts | output | 4 | {halted, host error, rollover, completion} |
| cfg_sts | output | 3 | {signalled system error, target abort, master abort} |
| dma_halt_req | output | 1 | DMA engines must stop issuing work |
| irq | output | 1 | Level interrupt |
| flr_evt | output | 1 | One-cycle frame-list rollover pulse |

## Verification
The assertions are checked on every cycle. They cover the following:
- A fatal error in RUN raises the halt request on the next cycle.
- The halt request only falls after a run command.
- The host-error and both abort bits are set after an abort.
- The system-error bit rises only with its enable.
- Sticky bits hold until cleared.
- The rollover pulse lasts one cycle.

Other behaviour can only be shown by the bench's scenarios, which check against a cycle model:
- The drain waits through a transaction still in flight.
- Aborts while halted are ignored by the sequencer.
- Set wins over a same-cycle clear.
- The threshold boundaries follow each `thr_log2` value, including clamping above 6.
- Exactly one rollover occurs over 8192 ticks.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
    typedef enum logic [1:0] {
        HS_RUN     = 2'd0,
        HS_DRAIN   = 2'd1,
        HS_HALTED  = 2'd2
    } halt_state_e;

    // bit positions of the software-visible status vector
    localparam int SB_CMPL   = 0;
    localparam int SB_ROLL   = 1;
    localparam int SB_FATAL  = 2;
    localparam int SB_HALTED = 3;
    localparam int NUM_STICKY = 3;

    // bit positions of the configuration-space error vector
    localparam int CB_MABORT = 0;
    localparam int CB_TABORT = 1;
    localparam int CB_SYSERR = 2;
    localparam int NUM_CFG   = 3;
endpackage

// File: rtl/hcf_halt_fsm.sv
module hcf_halt_fsm
    import hcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fatal_evt,
    input  logic xact_active,
    input  logic xact_done,
    input  logic run_cmd,
    output logic halt_req,
    output logic halted
);
    halt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN:    if (fatal_evt) state_d = HS_DRAIN;
            HS_DRAIN:  if (xact_done || !xact_active) state_d = HS_HALTED;
            HS_HALTED: if (run_cmd) state_d = HS_RUN;
            default:   state_d = HS_RUN;
        endcase
    end

    always_comb begin
        halt_req = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            HS_RUN:    ;
            HS_DRAIN:  halt_req = 1'b1;
            HS_HALTED: begin halt_req = 1'b1; halted = 1'b1; end
            default:   ;
        endcase
    end

    AST_HALT_AFTER_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RUN && fatal_evt) |=> halt_req); // R5
    AST_RESUME_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_req) |-> $past(run_cmd)); // R6
endmodule

// File: rtl/hcf_uframe_timer.sv
module hcf_uframe_timer #(
    parameter int UF_PER_FRAME  = 8,
    parameter int FRAME_ENTRIES = 1024,
    parameter int THR_W         = 3,
    parameter int THR_MAX_LOG2  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uframe_tick,
    input  logic [THR_W-1:0] thr_log2,
    output logic             wrap_now,
    output logic             thr_hit,
    output logic             flr_evt
);
    localparam int UF_BITS = $clog2(UF_PER_FRAME);
    localparam int FR_BITS = $clog2(FRAME_ENTRIES);
    localparam int CNT_W   = UF_BITS + FR_BITS;

    logic [CNT_W-1:0] cnt_q, cnt_inc, mask;
    logic [THR_W-1:0] eff_log2;
    logic             flr_q;

    always_comb begin
        cnt_inc  = cnt_q + CNT_W'(1);
        eff_log2 = (thr_log2 > THR_W'(THR_MAX_LOG2)) ? THR_W'(THR_MAX_LOG2) : thr_log2;
        mask     = (CNT_W'(1) << eff_log2) - CNT_W'(1);
    end

    assign wrap_now = uframe_tick && (cnt_q == {CNT_W{1'b1}});
    assign thr_hit  = uframe_tick && ((cnt_inc & mask) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flr_q <= 1'b0;
        end else begin
            if (uframe_tick) cnt_q <= cnt_inc;
            flr_q <= wrap_now;
        end
    end

    assign flr_evt = flr_q;

    AST_FLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flr_evt |=> !flr_evt); // R9
endmodule

// File: rtl/hcf_status_regs.sv
module hcf_status_regs
    import hcf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fatal_evt,
    input  logic                  mab_evt,
    input  logic                  tab_evt,
    input  logic                  wrap_now,
    input  logic                  thr_hit,
    input  logic                  cpl_posted,
    input  logic                  serr_en,
    input  logic [NUM_STICKY-1:0] sts_w1c,
    input  logic [NUM_CFG-1:0]    cfg_w1c,
    input  logic [NUM_STICKY-1:0] en_vec,
    output logic [NUM_STICKY-1:0] sts_bits,
    output logic [NUM_CFG-1:0]    cfg_bits,
    output logic                  irq
);
    logic [NUM_STICKY-1:0] sts_set, sts_q;
    logic [NUM_CFG-1:0]    cfg_set, cfg_q;
    logic                  pend_q;

    always_comb begin
        sts_set            = '0;
        sts_set[SB_CMPL]   = thr_hit && (pend_q || cpl_posted);
        sts_set[SB_ROLL]   = wrap_now;
        sts_set[SB_FATAL]  = fatal_evt;
        cfg_set            = '0;
        cfg_set[CB_MABORT] = mab_evt;
        cfg_set[CB_TABORT] = tab_evt;
        cfg_set[CB_SYSERR] = fatal_evt && serr_en;
    end

    // completion posted since the last threshold boundary
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (thr_hit) pend_q <= 1'b0;
        else              pend_q <= pend_q || cpl_posted;
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (!rst_n)          sts_q[i] <= 1'b0;
            else if (sts_set[i]) sts_q[i] <= 1'b1;
            else if (sts_w1c[i]) sts_q[i] <= 1'b0;
        end
    end

    for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n)          cfg_q[j] <= 1'b0;
            else if (cfg_set[j]) cfg_q[j] <= 1'b1;
            else if (cfg_w1c[j]) cfg_q[j] <= 1'b0;
        end
    end

    assign sts_bits = sts_q;
    assign cfg_bits = cfg_q;
    assign irq      = |(sts_q & en_vec);

    AST_FATAL_SETS_HSE: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_evt |=> sts_q[SB_FATAL]); // R2
    AST_BOTH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mab_evt && tab_evt) |=> (cfg_q[CB_MABORT] && cfg_q[CB_TABORT])); // R3
    AST_SSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[CB_SYSERR]) |-> $past(fatal_evt && serr_en)); // R4
    AST_HSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[SB_FATAL] && !sts_w1c[SB_FATAL]) |=> sts_q[SB_FATAL]); // R8
endmodule

// File: rtl/hc_fault_irq.sv
module hc_fault_irq
    import hcf_pkg::*;
#(
    parameter int UF_PER_FRAME  = 8,
    parameter int FRAME_ENTRIES = 1024,
    parameter int THR_W         = 3,
    parameter int THR_MAX_LOG2  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cpl,
    input  logic             rd_mabort,
    input  logic             rd_tabort,
    input  logic             xact_active,
    input  logic             xact_done,
    input  logic             uframe_tick,
    input  logic             cpl_posted,
    input  logic [THR_W-1:0] thr_log2,
    input  logic             en_cmpl,
    input  logic             en_roll,
    input  logic             en_fatal,
    input  logic             serr_en,
    input  logic             run_cmd,
    input  logic [2:0]       sts_w1c,
    input  logic [2:0]       cfg_w1c,
    output logic [3:0]       sts,
    output logic [2:0]       cfg_sts,
    output logic             dma_halt_req,
    output logic             irq,
    output logic             flr_evt
);
    logic                  mab_evt, tab_evt, fatal_evt;
    logic                  wrap_now, thr_hit, halted;
    logic [NUM_STICKY-1:0] en_vec, sts_bits;

    assign mab_evt   = rd_cpl && rd_mabort;
    assign tab_evt   = rd_cpl && rd_tabort;
    assign fatal_evt = mab_evt || tab_evt;

    always_comb begin
        en_vec           = '0;
        en_vec[SB_CMPL]  = en_cmpl;
        en_vec[SB_ROLL]  = en_roll;
        en_vec[SB_FATAL] = en_fatal;
    end

    hcf_halt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fatal_evt   (fatal_evt),
        .xact_active (xact_active),
        .xact_done   (xact_done),
        .run_cmd     (run_cmd),
        .halt_req    (dma_halt_req),
        .halted      (halted)
    );

    hcf_uframe_timer #(
        .UF_PER_FRAME  (UF_PER_FRAME),
        .FRAME_ENTRIES (FRAME_ENTRIES),
        .THR_W         (THR_W),
        .THR_MAX_LOG2  (THR_MAX_LOG2)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .uframe_tick (uframe_tick),
        .thr_log2    (thr_log2),
        .wrap_now    (wrap_now),
        .thr_hit     (thr_hit),
        .flr_evt     (flr_evt)
    );

    hcf_status_regs u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fatal_evt  (fatal_evt),
        .mab_evt    (mab_evt),
        .tab_evt    (tab_evt),
        .wrap_now   (wrap_now),
        .thr_hit    (thr_hit),
        .cpl_posted (cpl_posted),
        .serr_en    (serr_en),
        .sts_w1c    (sts_w1c),
        .cfg_w1c    (cfg_w1c),
        .en_vec     (en_vec),
        .sts_bits   (sts_bits),
        .cfg_bits   (cfg_sts),
        .irq        (irq)
    );

    assign sts = {halted, sts_bits};
endmodule

// File: tb/tb_hc_fault_irq.sv
module tb_hc_fault_irq;
    localparam int CLK_PERIOD = 10;
    localparam int UF    = 8;
    localparam int FR    = 1024;
    localparam int CNTM  = UF * FR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_cpl = 0, rd_mabort = 0, rd_tabort = 0, xact_active = 0, xact_done = 0;
    logic uframe_tick = 0, cpl_posted = 0, en_cmpl = 0, en_roll = 0, en_fatal = 0;
    logic serr_en = 0, run_cmd = 0;
    logic [2:0] thr_log2 = 0, sts_w1c = 0, cfg_w1c = 0;
    logic [3:0] sts;
    logic [2:0] cfg_sts;
    logic dma_halt_req, irq, flr_evt;

    hc_fault_irq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    // bench model: 0 RUN, 1 DRAIN, 2 HALTED
    int m_state = 0, m_cnt = 0;
    bit m_pend = 0, m_flr = 0;
    bit [2:0] m_sts = 0, m_cfg = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_irq();
        return (m_sts[0] && en_cmpl) || (m_sts[1] && en_roll) || (m_sts[2] && en_fatal);
    endfunction

    task automatic compare_all();
        chk("R10 sts[0]", sts[0], m_sts[0]);
        chk("R9 sts[1]",  sts[1], m_sts[1]);
        chk("R2 sts[2]",  sts[2], m_sts[2]);
        chk("R5 sts[3]",  sts[3], m_state == 2);
        chk("R3 cfg_sts[1:0]", cfg_sts[1:0], m_cfg[1:0]);
        chk("R4 cfg_sts[2]", cfg_sts[2], m_cfg[2]);
        chk("R5 dma_halt_req", dma_halt_req, m_state != 0);
        chk("R7 irq", irq, exp_irq());
        chk("R9 flr_evt", flr_evt, m_flr);
    endtask

    // one clock: model next state from current inputs, then compare
    task automatic cyc();
        bit fatal, ma, ta, wrap, hit;
        int eff, mask, n_state;
        bit [2:0] set_s, set_c;
        ma = rd_cpl && rd_mabort;
        ta = rd_cpl && rd_tabort;
        fatal = ma || ta;
        wrap = uframe_tick && (m_cnt == CNTM - 1);
        eff = (thr_log2 > 6) ? 6 : int'(thr_log2);
        mask = (1 << eff) - 1;
        hit = uframe_tick && ((((m_cnt + 1) % CNTM) & mask) == 0);
        set_s = {fatal, wrap, hit && (m_pend || cpl_posted)};
        set_c = {fatal && serr_en, ta, ma};
        n_state = m_state;
        case (m_state)
            0: if (fatal) n_state = 1;
            1: if (xact_done || !xact_active) n_state = 2;
            default: if (run_cmd) n_state = 0;
        endcase
        @(posedge clk);
        m_sts = set_s | (m_sts & ~sts_w1c);
        m_cfg = set_c | (m_cfg & ~cfg_w1c);
        m_pend = hit ? 1'b0 : (m_pend || cpl_posted);
        m_state = n_state;
        m_flr = wrap;
        if (uframe_tick) m_cnt = (m_cnt + 1) % CNTM;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        rd_cpl = 0; rd_mabort = 0; rd_tabort = 0; xact_done = 0;
        cpl_posted = 0; run_cmd = 0; sts_w1c = 0; cfg_w1c = 0; uframe_tick = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed, rolls;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sts", sts, 0);
        chk("R1 cfg_sts", cfg_sts, 0);
        chk("R1 dma_halt_req", dma_halt_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 flr_evt", flr_evt, 0);
        rst_n = 1;

        // R2: abort flags without rd_cpl ignored
        rd_mabort = 1; rd_tabort = 1; cyc();
        chk("R2 no cpl no fatal", {sts[2], dma_halt_req}, 2'b00);

        // R3/R4/R5: both aborts at once, drain waits on active transaction
        en_fatal = 1; serr_en = 1; xact_active = 1; rd_cpl = 1; cyc();
        chk("R3 both cfg bits", cfg_sts, 3'b111);
        chk("R5 drain started", {dma_halt_req, sts[3]}, 2'b10);
        rd_cpl = 0; rd_mabort = 0; rd_tabort = 0; cyc(); cyc();
        chk("R5 still draining", sts[3], 0);
        rd_cpl = 1; rd_mabort = 1; cyc();   // abort during DRAIN
        rd_cpl = 0; rd_mabort = 0;
        xact_done = 1; cyc(); xact_done = 0;
        chk("R5 halted after one transaction", sts[3], 1);
        // R6: abort while halted does not restart
        rd_cpl = 1; rd_tabort = 1; cyc(); rd_cpl = 0; rd_tabort = 0;
        chk("R6 stays halted", {dma_halt_req, sts[3]}, 2'b11);
        run_cmd = 1; cyc(); run_cmd = 0;
        chk("R6 run resumes", {dma_halt_req, sts[3]}, 2'b00);
        run_cmd = 1; cyc(); run_cmd = 0;
        chk("R6 run in RUN ignored", dma_halt_req, 0);

        // R7 enable gating, combinational
        en_fatal = 0; #1;
        chk("R7 irq masked", irq, 0);
        en_fatal = 1; #1;
        chk("R7 irq enabled", irq, 1);

        // R8: set wins over clear; then clear works
        serr_en = 0; sts_w1c = 3'b100; cfg_w1c = 3'b111; rd_cpl = 1; rd_mabort = 1; cyc();
        chk("R8 set beats clear", sts[2], 1);
        chk("R8 cfg set beats clear", cfg_sts, 3'b001);
        chk("R4 no sse when disabled", cfg_sts[2], 0);
        rd_cpl = 0; rd_mabort = 0; xact_active = 0; cyc();
        chk("R8 hse cleared", sts[2], 0);
        sts_w1c = 0; cfg_w1c = 0; run_cmd = 1; cyc(); run_cmd = 0;

        // R10 threshold boundaries for a few settings
        en_cmpl = 1;
        for (int t = 0; t < 8; t++) begin
            thr_log2 = 3'(t);
            sts_w1c = 3'b001; cyc(); sts_w1c = 0;
            cpl_posted = 1; cyc(); cpl_posted = 0;
            for (int k = 0; k < 70; k++) begin
                uframe_tick = 1; cyc(); uframe_tick = 0;
            end
            chk("R10 boundary reached", sts[0], 1);
        end

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                {en_cmpl, en_roll, en_fatal, serr_en} = 4'($urandom);
                thr_log2 = 3'($urandom);
            end
            rd_cpl      = ($urandom % 16) == 0;
            rd_mabort   = ($urandom % 2) == 0;
            rd_tabort   = ($urandom % 2) == 0;
            xact_active = ($urandom % 3) != 0;
            xact_done   = ($urandom % 4) == 0;
            uframe_tick = ($urandom % 2) == 0;
            cpl_posted  = ($urandom % 8) == 0;
            run_cmd     = ($urandom % 20) == 0;
            sts_w1c     = (($urandom % 10) == 0) ? 3'($urandom) : 3'b000;
            cfg_w1c     = (($urandom % 10) == 0) ? 3'($urandom) : 3'b000;
            cyc();
        end
        idle_inputs();

        // R9 exactly one rollover in CNTM+10 consecutive ticks
        rolls = 0;
        uframe_tick = 1;
        for (int k = 0; k < CNTM + 10; k++) begin
            cyc();
            if (flr_evt) rolls++;
        end
        uframe_tick = 0;
        chk("R9 one rollover per 8192 ticks", rolls, 1);
        chk("R9 rollover status", sts[1], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule